// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block decides which of six masters may drive a shared, PCI-style parallel bus. Requester 0 is the internal host master. Requesters 1 to 5 are the five external masters, in numerical order. Each requester has a configuration bit that puts it in a high group or a low group. Inside each group the grant rotates round-robin. The whole low group acts as a single extra requester that takes one turn in the high group's rotation. When that turn comes up, the low group's own ring picks which low device gets the bus.

The arbiter watches the bus framing and ready strobes. From them it learns when the owner of the grant has started a transaction and when the bus is idle. The next grant is handed out as soon as a transaction starts, while the bus is still busy. If a requester that ranks higher in the rotation asks for the bus, it can take a grant that has already been given. A request that appears on an idle bus is held off for one clock before any grant is driven. With no requests at all, the grant parks on the host master.

Top module: `duo_ring_arbiter`

## Requirements
- R1: While reset is high and on the first clock after it, every bit of `gnt` is 0. Reset sets both rotation pointers to requester 0, so the first rotation search starts at requester 1.
- R2: When `req` is all zero and `gnt` is all zero, `gnt` becomes 6'b000001 (parked on the host) on the next clock.
- R3: The bus is idle when `frame_n` and `irdy_n` are both 1. On an idle bus, any `req` bit that rises from 0 to 1 forces `gnt` to all zero on the next clock. On the clock after that, the winner is granted.
- R4: At most one bit of `gnt` is 1 in any cycle. A change from one nonzero grant to a different one always passes through at least one all-zero cycle.
- R5: Among requesters whose `prio_hi` bit is 1, the winner is the first requesting index after the last one that started a transaction, searched in circular order. Requesters that are not requesting are skipped.
- R6: The low group (`prio_hi` bit 0) holds one position in the high rotation, placed after index 5. When that position wins, the low device chosen is the first requesting low index after the last low device that started a transaction. The low pointer moves only when a low device starts a transaction.
- R7: A transaction start is a clock on which `frame_n` is sampled 0 after being 1 on the previous clock while a grant is asserted. On that clock the granted requester becomes the last owner. If the rotation then picks a different requester, `gnt` goes to all zero on the next clock and to the new winner on the clock after, even while the bus stays busy.
- R8: The bus is busy when `frame_n` or `irdy_n` is 0. If, while the bus is busy, a requester that ranks earlier in the rotation raises its request, the current grant is withdrawn on the next clock. That requester is granted one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 6 | Request per master: bit 0 is the host, bits 1 to 5 are external masters 0 to 4 |
| prio_hi | input | 6 | Group select per master: 1 puts it in the high group, 0 in the low group |
| frame_n | input | 1 | Bus framing strobe, active low |
| irdy_n | input | 1 | Bus initiator-ready strobe, active low |
| gnt | output | 6 | Registered grant, at most one bit set |

## Verification
The checker assumes that `req` and `prio_hi` change only between clock edges. It also assumes that `frame_n` falls only after the master holding `gnt` has seen that grant, so every transaction start has a well-defined owner. The bench drives all inputs on falling clock edges. It starts each transaction only while the expected grant is stable, and it holds `prio_hi` constant within a scenario. Preemption is exercised with `irdy_n` low and `frame_n` high, so the bus counts as busy without a framing edge moving the pointers.

// File: rtl/ring_arb_pkg.sv
package ring_arb_pkg;
  // Action taken on the grant register in one cycle
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_GAP  = 2'd1,
    STEP_GIVE = 2'd2
  } gnt_step_e;
endpackage

// File: rtl/ring_arb_pick.sv
// Circular first-set search starting one place after a pointer.
module ring_arb_pick #(
  parameter int W  = 7,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  mask,
  input  logic [IW-1:0] ptr,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    // Walk from farthest to nearest so the nearest match wins
    for (int off = W; off >= 1; off--) begin
      int p;
      p = (int'(ptr) + off) % W;
      if (mask[p]) begin
        valid = 1'b1;
        idx   = IW'(p);
      end
    end
  end
endmodule

// File: rtl/ring_arb_busmon.sv
// Bus phase tracking: idle detect, transaction start, fresh requests.
module ring_arb_busmon #(
  parameter int NUM_REQ = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_n,
  input  logic               irdy_n,
  input  logic [NUM_REQ-1:0] req,
  output logic               bus_idle,
  output logic               tx_start,
  output logic               req_fresh
);
  logic               frame_q;
  logic [NUM_REQ-1:0] req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= 1'b1;
      req_q   <= '0;
    end else begin
      frame_q <= frame_n;
      req_q   <= req;
    end
  end

  assign bus_idle  = frame_n & irdy_n;
  assign tx_start  = frame_q & ~frame_n;
  assign req_fresh = |(req & ~req_q);
endmodule

// File: rtl/duo_ring_arbiter.sv
module duo_ring_arbiter #(
  parameter int NUM_REQ  = 6,
  parameter int PARK_IDX = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req,
  input  logic [NUM_REQ-1:0] prio_hi,
  input  logic               frame_n,
  input  logic               irdy_n,
  output logic [NUM_REQ-1:0] gnt
);
  import ring_arb_pkg::*;

  localparam int HI_W     = NUM_REQ + 1;
  localparam int HI_IW    = $clog2(HI_W);
  localparam int LO_IW    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam int LOW_SLOT = NUM_REQ;

  logic               bus_idle, tx_start, req_fresh;
  logic [HI_IW-1:0]   hi_ptr, hi_idx;
  logic [LO_IW-1:0]   lo_ptr, lo_idx, owner_idx;
  logic               hi_valid, lo_valid, owner_valid;
  logic [NUM_REQ-1:0] lo_mask, target, gnt_q;
  logic [HI_W-1:0]    hi_mask;
  gnt_step_e          step;

  ring_arb_busmon #(.NUM_REQ(NUM_REQ)) u_mon (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .req      (req),
    .bus_idle (bus_idle),
    .tx_start (tx_start),
    .req_fresh(req_fresh)
  );

  // High ring: one entry per high requester plus the low-group slot on top
  assign lo_mask = req & ~prio_hi;
  assign hi_mask = {|lo_mask, req & prio_hi};

  ring_arb_pick #(.W(HI_W)) u_hi_ring (
    .mask (hi_mask),
    .ptr  (hi_ptr),
    .valid(hi_valid),
    .idx  (hi_idx)
  );

  ring_arb_pick #(.W(NUM_REQ)) u_lo_ring (
    .mask (lo_mask),
    .ptr  (lo_ptr),
    .valid(lo_valid),
    .idx  (lo_idx)
  );

  always_comb begin
    if (hi_valid && hi_idx == HI_IW'(LOW_SLOT) && lo_valid)
      target = NUM_REQ'(1) << lo_idx;
    else if (hi_valid && hi_idx != HI_IW'(LOW_SLOT))
      target = NUM_REQ'(1) << hi_idx;
    else
      target = NUM_REQ'(1) << PARK_IDX;
  end

  // Index of the master currently holding the grant
  always_comb begin
    owner_valid = 1'b0;
    owner_idx   = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (gnt_q[i]) begin
        owner_valid = 1'b1;
        owner_idx   = LO_IW'(i);
      end
    end
  end

  always_comb begin
    if (bus_idle && req_fresh)
      step = STEP_GAP;
    else if (gnt_q == target)
      step = STEP_HOLD;
    else if (gnt_q != '0)
      step = STEP_GAP;
    else
      step = STEP_GIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q <= '0;
    end else begin
      case (step)
        STEP_GAP:  gnt_q <= '0;
        STEP_GIVE: gnt_q <= target;
        default:   gnt_q <= gnt_q;
      endcase
    end
  end

  // The master that starts a transaction drops to the back of its ring
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_ptr <= HI_IW'(PARK_IDX);
      lo_ptr <= LO_IW'(PARK_IDX);
    end else if (tx_start && owner_valid) begin
      if (prio_hi[owner_idx]) begin
        hi_ptr <= HI_IW'(owner_idx);
      end else begin
        hi_ptr <= HI_IW'(LOW_SLOT);
        lo_ptr <= owner_idx;
      end
    end
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/duo_ring_arbiter_chk.sv
module duo_ring_arbiter_chk #(
  parameter int NUM_REQ  = 6,
  parameter int PARK_IDX = 0
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_REQ-1:0] req,
  input logic               frame_n,
  input logic               irdy_n,
  input logic [NUM_REQ-1:0] gnt
);
  logic [NUM_REQ-1:0] req_seen;

  always_ff @(posedge clk) begin
    if (rst) req_seen <= '0;
    else     req_seen <= req;
  end

  p_single_grant_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  p_gap_on_change_r4: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0) |=> (gnt == '0 || gnt == $past(gnt)));

  p_idle_holdoff_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_n && irdy_n && ((req & ~req_seen) != '0)) |=> (gnt == '0));

  p_park_host_r2: assert property (@(posedge clk) disable iff (rst)
    (req == '0 && gnt == '0) |=> (gnt == (NUM_REQ'(1) << PARK_IDX)));
endmodule

bind duo_ring_arbiter duo_ring_arbiter_chk #(.NUM_REQ(NUM_REQ), .PARK_IDX(PARK_IDX)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .req    (req),
  .frame_n(frame_n),
  .irdy_n (irdy_n),
  .gnt    (gnt)
);

// File: tb/duo_ring_arbiter_test.sv
module duo_ring_arbiter_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] req, prio_hi, gnt;
  logic       frame_n, irdy_n;
  int         checks = 0;
  int         failures = 0;
  bit         finished = 1'b0;

  duo_ring_arbiter uut (
    .clk(clk), .rst(rst), .req(req), .prio_hi(prio_hi),
    .frame_n(frame_n), .irdy_n(irdy_n), .gnt(gnt)
  );

  always #5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_gnt(input string rq, input logic [5:0] exp);
    checks++;
    if (gnt !== exp) begin
      failures++;
      $display("FAIL %s gnt=%b expected=%b", rq, gnt, exp);
    end
  endtask

  task automatic do_reset(input logic [5:0] prio);
    @(negedge clk);
    rst = 1'b1; req = '0; prio_hi = prio; frame_n = 1'b1; irdy_n = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  // Owner starts a transaction; expect gap, then next winner while busy
  task automatic run_txn(input string rq, input logic [5:0] next_exp);
    frame_n = 1'b0; irdy_n = 1'b0;
    step(2);
    expect_gnt("R4", 6'b000000);
    step(1);
    expect_gnt(rq, next_exp);
    frame_n = 1'b1; irdy_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset_park;
    do_reset(6'b111111);
    expect_gnt("R1", 6'b000000);
    step(1);
    expect_gnt("R2", 6'b000001);
  endtask

  task automatic t_holdoff;
    do_reset(6'b111111);
    step(1);
    req = 6'b001000;
    step(1);
    expect_gnt("R3", 6'b000000);
    step(1);
    expect_gnt("R3", 6'b001000);
    req = 6'b000000;
    step(1);
    expect_gnt("R4", 6'b000000);
    step(1);
    expect_gnt("R2", 6'b000001);
    req = 6'b000001;
    step(1);
    expect_gnt("R3", 6'b000000);
    step(1);
    expect_gnt("R3", 6'b000001);
  endtask

  task automatic t_high_rotation;
    do_reset(6'b111111);
    step(1);
    req = 6'b010100;
    step(2);
    expect_gnt("R5", 6'b000100);
    run_txn("R7", 6'b010000);
    run_txn("R5", 6'b000100);
    run_txn("R5", 6'b010000);
  endtask

  task automatic t_two_level;
    do_reset(6'b000011);
    step(1);
    req = 6'b111010;
    step(2);
    expect_gnt("R5", 6'b000010);
    run_txn("R6", 6'b001000);
    run_txn("R6", 6'b000010);
    run_txn("R6", 6'b010000);
    run_txn("R6", 6'b000010);
    run_txn("R6", 6'b100000);
    run_txn("R6", 6'b000010);
    run_txn("R6", 6'b001000);
  endtask

  task automatic t_preempt;
    do_reset(6'b111111);
    step(1);
    req = 6'b010000;
    step(2);
    expect_gnt("R8", 6'b010000);
    irdy_n = 1'b0;
    step(1);
    expect_gnt("R8", 6'b010000);
    req = 6'b010100;
    step(1);
    expect_gnt("R8", 6'b000000);
    step(1);
    expect_gnt("R8", 6'b000100);
    irdy_n = 1'b1;
  endtask

  initial begin
    t_reset_park();
    t_holdoff();
    t_high_rotation();
    t_two_level();
    t_preempt();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog gnt=%b expected=completion", gnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule